// File: doc/BRIEF.md
# 16-bit Word SECDED Protection Unit

This unit guards 16-bit data words held in a small word memory. On a normal write it computes six check bits and presents a 22-bit codeword, together with its address, to the memory one clock later. On a read, the memory returns a stored codeword. The unit checks it, repairs any single flipped bit and detects any pair of flipped bits. One clock after the read request it returns the data word and a 2-bit status code that is held for software. The code is an extended Hamming code: five positional parity bits plus one bit that makes the whole codeword even parity.

A raw write path exists for fault injection. While the special-mode input is high, the caller supplies the data and check bits itself, and they are stored exactly as given, without being recomputed. This lets software plant single and double errors and see how its error handling reacts. A memory that has never been written reads as all ones in both fields, and the unit reports that pattern as uncorrectable.

Top module: `secded_word_ecc`

## Requirements
- R1: When `wr_en` is high, on the next clock `mem_we` is high, `mem_addr` carries `wr_addr`, and `mem_code` is {check[5:0], data[15:0]}. Data bits 0..15 occupy, in ascending order, the Hamming positions 3,5,6,7,9..15,17..21 (positions that are not powers of two). For i in 0..4, check[i] sits at position 2^i and is the XOR of the data bits whose position has bit i set. check[5] makes the XOR of all 22 bits zero.
- R2: `rd_valid` is high for exactly the one clock that follows each clock with `rd_en` high. `rd_data` and `rd_status` are valid in that clock.
- R3: A codeword without errors returns its data with status 00. The status value 01 never occurs.
- R4: A codeword with exactly one data bit flipped returns the original data with status 10.
- R5: A codeword with exactly one check bit flipped returns its data unchanged with status 10.
- R6: A codeword with two bits flipped returns status 11 and the stored data field without correction.
- R7: The erased pattern (all 22 bits one) reads as status 11 with data 0xFFFF.
- R8: When `dbg_mode` and `dbg_wr_en` are high and `wr_en` is low, on the next clock `mem_we` is high, `mem_addr` is `dbg_addr` and `mem_code` is {`dbg_check`, `dbg_data`}, with no recomputation.
- R9: When `dbg_mode` is low, `dbg_wr_en` causes no memory write.
- R10: `rd_status` holds its value until the next read or a `status_clr` pulse. A clear alone sets it to 00. A read in the same clock as a clear takes precedence over the clear.
- R11: When `wr_en` and a permitted raw write arrive in the same clock, only the normal write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Normal encoded write request |
| wr_addr | input | ADDR_W | Address of the normal write |
| wr_data | input | 16 | Data of the normal write |
| dbg_mode | input | 1 | Special mode; allows raw writes |
| dbg_wr_en | input | 1 | Raw write request |
| dbg_addr | input | ADDR_W | Address of the raw write |
| dbg_data | input | 16 | Raw data field |
| dbg_check | input | 6 | Raw check field |
| rd_en | input | 1 | Read request; the codeword is on `rd_code` in the same clock |
| rd_code | input | 22 | Codeword fetched from memory |
| status_clr | input | 1 | Clears the held status |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_code | output | 22 | Codeword to store |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Corrected data word |
| rd_status | output | 2 | 00 clean, 10 corrected, 11 uncorrectable |

## Verification
Through the normal write path every stored codeword is valid, so none of the error cases can be reached from it. The bench plants faults through the raw path. It computes the correct check bits from the R1 layout, then flips chosen data bits, each check bit in turn, or pairs of bits before the raw write. It then reads the word back through the checking path. The erased case is reached by reading memory that has never been written. The status-hold rules are exercised by idle cycles, clear pulses and a clear that coincides with a read.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W = 16;
    localparam int HAM_W  = 5;
    localparam int CHK_W  = HAM_W + 1;
    localparam int CODE_W = DATA_W + CHK_W;
    localparam int NPOS   = DATA_W + HAM_W;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b10,
        ST_FATAL = 2'b11
    } ecc_status_e;

    typedef logic [NPOS:1] pos_vec_t;

    // place data bits at the non-power-of-two positions, parity slots zero
    function automatic pos_vec_t place_data(input logic [DATA_W-1:0] d);
        pos_vec_t v;
        int k;
        v = '0;
        k = 0;
        for (int p = 1; p <= NPOS; p++) begin
            if ((p & (p - 1)) != 0) begin
                v[p] = d[k];
                k++;
            end
        end
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] take_data(input pos_vec_t v);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p <= NPOS; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = v[p];
                k++;
            end
        end
        return d;
    endfunction

    function automatic logic [HAM_W-1:0] syndrome(input pos_vec_t v);
        logic [HAM_W-1:0] s;
        s = '0;
        for (int p = 1; p <= NPOS; p++) begin
            if (v[p]) s = s ^ HAM_W'(p);
        end
        return s;
    endfunction

    function automatic pos_vec_t to_positions(input logic [DATA_W-1:0] d,
                                              input logic [HAM_W-1:0]  h);
        pos_vec_t v;
        v = place_data(d);
        for (int i = 0; i < HAM_W; i++) begin
            v[1 << i] = h[i];
        end
        return v;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  check_o
);
    pos_vec_t         spread;
    logic [HAM_W-1:0] ham;

    always_comb begin
        spread  = place_data(data_i);
        ham     = syndrome(spread);
        spread  = to_positions(data_i, ham);
        check_o = {^spread, ham};
    end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output ecc_status_e       status_o
);
    pos_vec_t         v;
    logic [HAM_W-1:0] syn;
    logic             odd;
    logic             hit;

    always_comb begin
        v        = to_positions(code_i[DATA_W-1:0], code_i[DATA_W +: HAM_W]);
        syn      = syndrome(v);
        odd      = ^code_i;
        hit      = 1'b0;
        data_o   = code_i[DATA_W-1:0];
        status_o = ST_CLEAN;
        if (odd) begin
            status_o = ST_FIXED;
            if (syn != '0) begin
                for (int p = 1; p <= NPOS; p++) begin
                    if (HAM_W'(p) == syn) begin
                        v[p] = ~v[p];
                        hit  = 1'b1;
                    end
                end
                if (hit) data_o   = take_data(v);
                else     status_o = ST_FATAL;
            end
        end else if (syn != '0) begin
            status_o = ST_FATAL;
        end
    end
endmodule

// File: rtl/secded_word_ecc.sv
module secded_word_ecc
    import secded_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              dbg_mode,
    input  logic              dbg_wr_en,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic [15:0]       dbg_data,
    input  logic [5:0]        dbg_check,
    input  logic              rd_en,
    input  logic [21:0]       rd_code,
    input  logic              status_clr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [21:0]       mem_code,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic [1:0]        rd_status
);
    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] code;
        logic              valid;
        logic [DATA_W-1:0] data;
        ecc_status_e       status;
    } state_t;

    state_t            st_d, st_q;
    logic [CHK_W-1:0]  enc_check;
    logic [DATA_W-1:0] dec_data;
    ecc_status_e       dec_status;

    secded_enc u_enc (
        .data_i  (wr_data),
        .check_o (enc_check)
    );

    secded_dec u_dec (
        .code_i   (rd_code),
        .data_o   (dec_data),
        .status_o (dec_status)
    );

    always_comb begin
        st_d       = st_q;
        st_d.we    = 1'b0;
        st_d.valid = 1'b0;
        if (wr_en) begin
            st_d.we   = 1'b1;
            st_d.addr = wr_addr;
            st_d.code = {enc_check, wr_data};
        end else if (dbg_wr_en && dbg_mode) begin
            st_d.we   = 1'b1;
            st_d.addr = dbg_addr;
            st_d.code = {dbg_check, dbg_data};
        end
        if (rd_en) begin
            st_d.valid  = 1'b1;
            st_d.data   = dec_data;
            st_d.status = dec_status;
        end else if (status_clr) begin
            st_d.status = ST_CLEAN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{we: 1'b0, addr: '0, code: '0, valid: 1'b0,
                      data: '0, status: ST_CLEAN};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we    = st_q.we;
    assign mem_addr  = st_q.addr;
    assign mem_code  = st_q.code;
    assign rd_valid  = st_q.valid;
    assign rd_data   = st_q.data;
    assign rd_status = st_q.status;
endmodule

// File: rtl/secded_word_ecc_chk.sv
module secded_word_ecc_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [15:0]       wr_data,
    input logic              dbg_mode,
    input logic              dbg_wr_en,
    input logic [ADDR_W-1:0] dbg_addr,
    input logic [15:0]       dbg_data,
    input logic [5:0]        dbg_check,
    input logic              rd_en,
    input logic              status_clr,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [21:0]       mem_code,
    input logic              rd_valid,
    input logic [1:0]        rd_status
);
    assert_wr_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_we && mem_code[15:0] == $past(wr_data)));

    assert_rd_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_rd_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_no_code01_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status != 2'b01);

    assert_raw_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wr_en && dbg_mode && !wr_en) |=>
        (mem_we && mem_addr == $past(dbg_addr) &&
         mem_code == {$past(dbg_check), $past(dbg_data)}));

    assert_raw_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wr_en && !dbg_mode && !wr_en) |=> !mem_we);

    assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !status_clr) |=> $stable(rd_status));

    assert_status_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !rd_en) |=> rd_status == 2'b00);

    assert_write_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dbg_wr_en) |=> mem_code[15:0] == $past(wr_data));
endmodule

bind secded_word_ecc secded_word_ecc_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_secded_word_ecc.sv
module tb_secded_word_ecc;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en, dbg_mode, dbg_wr_en, rd_en, status_clr;
    logic [AW-1:0] wr_addr, dbg_addr;
    logic [15:0]   wr_data, dbg_data;
    logic [5:0]    dbg_check;
    logic [21:0]   rd_code;
    logic          mem_we, rd_valid;
    logic [AW-1:0] mem_addr;
    logic [21:0]   mem_code;
    logic [15:0]   rd_data;
    logic [1:0]    rd_status;

    logic [21:0] mem [16];

    int n_checks = 0;
    int n_fails  = 0;

    logic [15:0] exp_d_q [$];
    logic [1:0]  exp_s_q [$];
    string       tag_q   [$];

    always #4 clk = ~clk;

    secded_word_ecc #(.ADDR_W(AW)) dut (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .dbg_mode, .dbg_wr_en,
        .dbg_addr, .dbg_data, .dbg_check, .rd_en, .rd_code, .status_clr,
        .mem_we, .mem_addr, .mem_code, .rd_valid, .rd_data, .rd_status
    );

    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_code;

    // reference check bits from the layout in R1
    function automatic logic [5:0] ref_check(input logic [15:0] d);
        logic [5:0] c;
        int pos;
        c   = '0;
        pos = 1;
        for (int k = 0; k < 16; k++) begin
            pos++;
            while ((pos & (pos - 1)) == 0) pos++;
            for (int i = 0; i < 5; i++)
                if (((pos >> i) & 1) == 1) c[i] = c[i] ^ d[k];
        end
        c[5] = ^{c[4:0], d};
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares results against the scoreboard queue
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_d_q.size() == 0) begin
                check("R2 unexpected rd_valid", 1, 0);
            end else begin
                logic [15:0] ed;
                logic [1:0]  es;
                string       t;
                ed = exp_d_q.pop_front();
                es = exp_s_q.pop_front();
                t  = tag_q.pop_front();
                check({t, " data"}, rd_data, ed);
                check({t, " status"}, rd_status, es);
            end
        end
    end

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic raw_write(input logic [AW-1:0] a, input logic [15:0] d,
                             input logic [5:0] c, input logic mode);
        @(negedge clk);
        dbg_mode = mode; dbg_wr_en = 1'b1; dbg_addr = a;
        dbg_data = d; dbg_check = c;
        @(negedge clk);
        dbg_wr_en = 1'b0; dbg_mode = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [15:0] ed,
                           input logic [1:0] es, input string t);
        @(negedge clk);
        rd_en = 1'b1; rd_code = mem[a];
        exp_d_q.push_back(ed); exp_s_q.push_back(es); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        check("watchdog expired", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] pats [4];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF;
        pats[2] = 16'hA5C3; pats[3] = 16'h1234;
        for (int i = 0; i < 16; i++) mem[i] = '1;
        rst_n = 1'b0; wr_en = 0; dbg_mode = 0; dbg_wr_en = 0; rd_en = 0;
        status_clr = 0; wr_addr = '0; dbg_addr = '0; wr_data = '0;
        dbg_data = '0; dbg_check = '0; rd_code = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset rd_valid", rd_valid, 0);
        check("R10 reset status", rd_status, 0);
        check("R1 reset mem_we", mem_we, 0);

        // erased location
        do_read(0, 16'hFFFF, 2'b11, "R7 erased");

        // clean writes and reads with encoding check
        for (int i = 0; i < 4; i++) begin
            do_write(AW'(i + 1), pats[i]);
            check("R1 stored codeword", mem[i + 1], {ref_check(pats[i]), pats[i]});
            do_read(AW'(i + 1), pats[i], 2'b00, "R3 clean");
        end

        // single data-bit errors via raw path
        for (int b = 0; b < 16; b += 5) begin
            logic [15:0] d;
            d = 16'h3C5A;
            raw_write(6, d ^ (16'h1 << b), ref_check(d), 1'b1);
            check("R8 raw stored", mem[6], {ref_check(d), d ^ (16'h1 << b)});
            do_read(6, d, 2'b10, "R4 data flip");
        end
        // check-bit errors
        for (int i = 0; i < 6; i++) begin
            raw_write(7, 16'h9E01, ref_check(16'h9E01) ^ (6'h1 << i), 1'b1);
            do_read(7, 16'h9E01, 2'b10, "R5 check flip");
        end
        // double errors
        raw_write(8, 16'h4444 ^ 16'h0204, ref_check(16'h4444), 1'b1);
        do_read(8, 16'h4644 ^ 16'h0004, 2'b11, "R6 two data bits");
        raw_write(8, 16'h4444 ^ 16'h0001, ref_check(16'h4444) ^ 6'h04, 1'b1);
        do_read(8, 16'h4445, 2'b11, "R6 data and check");

        // status held while idle, then cleared
        repeat (3) @(negedge clk);
        check("R10 status held", rd_status, 2'b11);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        check("R10 status cleared", rd_status, 2'b00);

        // read coinciding with clear: read wins
        raw_write(9, 16'h0F0F, ref_check(16'h0F0F) ^ 6'h20, 1'b1);
        status_clr = 1'b1;
        do_read(9, 16'h0F0F, 2'b10, "R10 read beats clear");
        status_clr = 1'b0;
        @(negedge clk);
        check("R10 status after read+clear", rd_status, 2'b10);

        // raw write blocked without special mode
        do_write(10, 16'h7777);
        raw_write(10, 16'h0000, 6'h00, 1'b0);
        check("R9 memory untouched", mem[10], {ref_check(16'h7777), 16'h7777});
        do_read(10, 16'h7777, 2'b00, "R9 blocked raw write");

        // simultaneous writes: normal one wins
        do_write(11, 16'h1111);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12; wr_data = 16'hBEEF;
        dbg_mode = 1'b1; dbg_wr_en = 1'b1; dbg_addr = 11;
        dbg_data = 16'h0000; dbg_check = 6'h3F;
        @(negedge clk);
        wr_en = 1'b0; dbg_wr_en = 1'b0; dbg_mode = 1'b0;
        @(negedge clk);
        do_read(12, 16'hBEEF, 2'b00, "R11 normal write done");
        do_read(11, 16'h1111, 2'b00, "R11 raw write dropped");

        repeat (4) @(negedge clk);
        check("R2 all reads answered", exp_d_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule